// File: doc/BRIEF.md
# Protocol Controller Register Read Port

This block is the register-access side of a small storage-bus protocol controller. It sits on a byte-wide memory-mapped bus. It holds a bank of readback registers, a 16-byte transfer buffer and an interrupt line. To form the register index, the block shifts the bus address right by a configurable amount.

Most reads return the stored register contents. Three registers are different, because reading them changes state:

- The buffer data register removes one byte from the transfer buffer and raises the interrupt.
- The interrupt cause register returns its contents and clears itself. It also tidies the status and sequence registers and drops the interrupt line.
- The count-high register returns a fixed identifier until software has written it once.

Side effects happen only on a single-cycle read strobe. Read data is registered and is valid in the cycle after the strobe. Writes are modelled only as far as the read side needs. A write to the buffer data register pushes a byte. Any other write stores its value, and a write to count-high marks that register as written.

Top module: `ctl_regport`

## Requirements
- R1: The register index is the bus address shifted right by parameter SHIFT. Address bits below the shift are ignored.
- R2: Read data is loaded at the clock edge that samples `rd_stb`. It holds its value in every cycle with no strobe.
- R3: Status phase field = status bits [2:0]; a non-zero phase means data-in. In data-in, a read of the buffer data register (index 2) with a non-zero byte count returns the oldest buffered byte, advances the read pointer and decrements the count. Bytes therefore come out in write order.
- R4: When the phase field is zero (data-out), such a read returns 0x00 and decrements the count. The read pointer does not move.
- R5: Every buffer data read that consumes a byte drives `irq` high from the next cycle.
- R6: A buffer data read with a zero count changes no state. It returns the last byte value that a buffer read produced.
- R7: When a buffer data read leaves the count at zero, both buffer pointers return to zero. The next pushed byte is therefore the next one popped.
- R8: The buffer holds 16 bytes. A push to a full buffer is ignored.
- R9: A read of the interrupt cause register (index 5) returns its contents from before the read. It clears the register to zero and drives `irq` low.
- R10: The same read clears status bit 4 (terminal count) and keeps the other status bits. It loads the sequence-step register (index 6) with 0x04.
- R11: A read of count-high (index 1) returns parameter CHIP_ID until index 1 has been written at least once. After that it returns the stored value, including zero.
- R12: A read of any other index, including status (index 4), returns the stored value and has no side effect.
- R13: Reset, synchronous and active-high, does the following:
  - clears every register, both pointers, the count and the written flag;
  - drives `irq` low.
- R14: A write strobe in the same cycle as a read strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches the following on every cycle:
- the interrupt line going high after a consuming pop and low after an interrupt-register read;
- the buffer count staying within capacity and falling by one per pop;
- a full buffer keeping its count;
- read data holding between strobes;
- the identifier before the first count-high write;
- the quiet state after reset.

Only the bench scenarios can show the following:
- byte ordering;
- the zero substitution in data-out and the stalled read pointer;
- the pointer rewind when the buffer empties;
- the clearing of status and sequence bits;
- address aliasing under the shift;
- the dropping of colliding writes.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  // Register indices; the read-side effects depend on these positions
  localparam int IDX_CNT_LO = 0;
  localparam int IDX_CNT_HI = 1;
  localparam int IDX_FIFO   = 2;
  localparam int IDX_CMD    = 3;
  localparam int IDX_STAT   = 4;
  localparam int IDX_INTR   = 5;
  localparam int IDX_SEQ    = 6;

  // Status layout
  localparam int          STAT_TC_BIT = 4;
  localparam logic [7:0]  STAT_PHASE  = 8'h07;
  // Sequence-step value after an interrupt acknowledge
  localparam logic [7:0]  SEQ_DONE    = 8'h04;

  typedef enum logic [2:0] {
    ACC_PLAIN,
    ACC_FIFO,
    ACC_INTR,
    ACC_CNTHI
  } acc_kind_e;

  function automatic acc_kind_e classify(input int idx);
    case (idx)
      IDX_FIFO:   return ACC_FIFO;
      IDX_INTR:   return ACC_INTR;
      IDX_CNT_HI: return ACC_CNTHI;
      default:    return ACC_PLAIN;
    endcase
  endfunction
endpackage

// File: rtl/ctl_xfer_buf.sv
module ctl_xfer_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          pop_adv,
  output logic [DW-1:0] head,
  output logic [CW-1:0] fill,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          push_ok, pop_ok, rewind;

  assign full    = (fill == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (fill != '0);
  // Count reaches (or stays at) zero after this pop
  assign rewind  = pop && !push_ok && (fill <= CW'(1));

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // Storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  assign head = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (rewind) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (push_ok)           wptr <= bump(wptr);
        if (pop_ok && pop_adv) rptr <= bump(rptr);
      end
      case ({push_ok, pop_ok})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/ctl_reg_file.sv
module ctl_reg_file
  import ctl_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int DW    = 8,
  localparam int NREG = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             fifo_ld,
  input  logic [DW-1:0]    fifo_val,
  input  logic             intr_clr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_val,
  output logic [DW-1:0]    stat_val,
  output logic             hi_written
);
  logic [NREG-1:0][DW-1:0] regs;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    logic          hit;
    assign hit     = wr_en && (wr_idx == IDX_W'(g));
    assign regs[g] = q;

    if (g == IDX_FIFO) begin : g_fifo
      // Holds the byte most recently produced by a buffer read
      always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (fifo_ld) q <= fifo_val;
      end
    end else if (g == IDX_INTR) begin : g_intr
      always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (intr_clr) q <= '0;
        else if (hit)      q <= wr_data;
      end
    end else if (g == IDX_STAT) begin : g_stat
      always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (intr_clr) q[STAT_TC_BIT] <= 1'b0;
        else if (hit)      q <= wr_data;
      end
    end else if (g == IDX_SEQ) begin : g_seq
      always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (intr_clr) q <= DW'(SEQ_DONE);
        else if (hit)      q <= wr_data;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (hit) q <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hi_written <= 1'b0;
    else if (wr_en && wr_idx == IDX_W'(IDX_CNT_HI)) hi_written <= 1'b1;
  end

  assign rd_val   = regs[rd_idx];
  assign stat_val = regs[IDX_STAT];
endmodule

// File: rtl/ctl_regport.sv
module ctl_regport
  import ctl_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          SHIFT   = 0,
  parameter int          IDX_W   = 4,
  parameter int          DEPTH   = 16,
  parameter int          DW      = 8,
  parameter logic [DW-1:0] CHIP_ID = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] reg_idx;
  acc_kind_e        kind;
  logic             wr_go, pio_in, pop_ok, intr_clr, hi_written, full;
  logic [DW-1:0]    head, pop_byte, rd_val, stat_val, rd_next;
  logic [CW-1:0]    fill;

  assign reg_idx  = IDX_W'(bus_addr >> SHIFT);
  assign kind     = classify(int'(reg_idx));
  assign wr_go    = wr_stb && !rd_stb;
  assign pio_in   = (stat_val & DW'(STAT_PHASE)) != '0;
  assign pop_ok   = rd_stb && (kind == ACC_FIFO) && (fill != '0);
  assign intr_clr = rd_stb && (kind == ACC_INTR);
  assign pop_byte = pio_in ? head : '0;

  ctl_xfer_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_go && kind == ACC_FIFO),
    .push_data (wr_data),
    .pop       (rd_stb && kind == ACC_FIFO),
    .pop_adv   (pio_in),
    .head      (head),
    .fill      (fill),
    .full      (full)
  );

  ctl_reg_file #(.IDX_W(IDX_W), .DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_go && kind != ACC_FIFO),
    .wr_idx     (reg_idx),
    .wr_data    (wr_data),
    .fifo_ld    (pop_ok),
    .fifo_val   (pop_byte),
    .intr_clr   (intr_clr),
    .rd_idx     (reg_idx),
    .rd_val     (rd_val),
    .stat_val   (stat_val),
    .hi_written (hi_written)
  );

  always_comb begin
    case (kind)
      ACC_FIFO:  rd_next = pop_ok ? pop_byte : rd_val;
      ACC_CNTHI: rd_next = hi_written ? rd_val : CHIP_ID;
      default:   rd_next = rd_val;  // interrupt cause returns pre-clear value
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (rd_stb)        rd_data <= rd_next;
      if (intr_clr)      irq     <= 1'b0;
      else if (pop_ok)   irq     <= 1'b1;
    end
  end
endmodule

// File: rtl/ctl_regport_chk.sv
module ctl_regport_chk #(
  parameter int            IDX_W   = 4,
  parameter int            DW      = 8,
  parameter int            DEPTH   = 16,
  parameter int            CW      = 5,
  parameter logic [DW-1:0] CHIP_ID = 8'hA5
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_stb,
  input logic             wr_stb,
  input logic [IDX_W-1:0] idx,
  input logic [CW-1:0]    fill,
  input logic             hi_written,
  input logic             irq,
  input logic [DW-1:0]    rd_data
);
  localparam logic [IDX_W-1:0] I_FIFO  = IDX_W'(ctl_pkg::IDX_FIFO);
  localparam logic [IDX_W-1:0] I_INTR  = IDX_W'(ctl_pkg::IDX_INTR);
  localparam logic [IDX_W-1:0] I_CNTHI = IDX_W'(ctl_pkg::IDX_CNT_HI);

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data)); // R2
  AST_POP_COUNT: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && idx == I_FIFO && fill != '0) |=> (fill == $past(fill) - CW'(1))); // R3
  AST_POP_IRQ: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && idx == I_FIFO && fill != '0) |=> irq); // R5
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && idx == I_FIFO && fill == '0) |=> (fill == '0)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH)); // R8
  AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !rd_stb && idx == I_FIFO && fill == CW'(DEPTH)) |=> (fill == CW'(DEPTH))); // R8
  AST_INTR_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && idx == I_INTR) |=> !irq); // R9
  AST_ID_BEFORE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && idx == I_CNTHI && !hi_written) |=> (rd_data == CHIP_ID)); // R11
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq && fill == '0 && !hi_written)); // R13
endmodule

bind ctl_regport ctl_regport_chk #(
  .IDX_W(IDX_W), .DW(DW), .DEPTH(DEPTH), .CW(CW), .CHIP_ID(CHIP_ID)
) u_chk (
  .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb), .idx(reg_idx),
  .fill(fill), .hi_written(hi_written), .irq(irq), .rd_data(rd_data)
);

// File: tb/test_ctl_regport.sv
`timescale 1ns/1ps
module test_ctl_regport;
  localparam int          SH   = 2;
  localparam logic [7:0]  CHIP = 8'hA5;
  localparam logic [3:0]  I_HI = 4'd1, I_FF = 4'd2, I_ST = 4'd4, I_IN = 4'd5, I_SQ = 4'd6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  ctl_regport #(.ADDR_W(8), .SHIFT(SH), .CHIP_ID(CHIP)) i_ctl_regport (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  // {is_read, index, write data, expected read data}
  localparam int NV = 32;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, I_ST, 8'h01, 8'h00},
    {1'b1, I_ST, 8'h00, 8'h01},  // R12
    {1'b1, I_ST, 8'h00, 8'h01},  // R12
    {1'b0, I_FF, 8'h11, 8'h00},
    {1'b0, I_FF, 8'h22, 8'h00},
    {1'b0, I_FF, 8'h33, 8'h00},
    {1'b1, I_FF, 8'h00, 8'h11},  // R3
    {1'b1, I_FF, 8'h00, 8'h22},  // R3
    {1'b1, I_FF, 8'h00, 8'h33},  // R3
    {1'b1, I_FF, 8'h00, 8'h33},  // R6
    {1'b1, I_HI, 8'h00, CHIP},   // R11
    {1'b0, I_HI, 8'h00, 8'h00},
    {1'b1, I_HI, 8'h00, 8'h00},  // R11
    {1'b0, I_HI, 8'h7E, 8'h00},
    {1'b1, I_HI, 8'h00, 8'h7E},  // R11
    {1'b0, I_IN, 8'h9C, 8'h00},
    {1'b1, I_IN, 8'h00, 8'h9C},  // R9
    {1'b1, I_IN, 8'h00, 8'h00},  // R9
    {1'b0, I_ST, 8'h13, 8'h00},
    {1'b0, I_SQ, 8'h01, 8'h00},
    {1'b1, I_IN, 8'h00, 8'h00},  // R9
    {1'b1, I_ST, 8'h00, 8'h03},  // R10
    {1'b1, I_SQ, 8'h00, 8'h04},  // R10
    {1'b0, I_ST, 8'h00, 8'h00},
    {1'b0, I_FF, 8'h44, 8'h00},
    {1'b0, I_FF, 8'h55, 8'h00},
    {1'b0, I_FF, 8'h66, 8'h00},
    {1'b1, I_FF, 8'h00, 8'h00},  // R4
    {1'b0, I_ST, 8'h02, 8'h00},
    {1'b1, I_FF, 8'h00, 8'h44},  // R4
    {1'b1, I_FF, 8'h00, 8'h55},  // R4
    {1'b1, I_FF, 8'h00, 8'h55}   // R6
  };

  function automatic logic [7:0] adr(input logic [3:0] i);
    return {2'b00, i, 2'b00};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd_raw(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    d = rd_data;
  endtask

  task automatic rd(input logic [3:0] i, output logic [7:0] d);
    rd_raw(adr(i), d);
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] v);
    @(negedge clk);
    bus_addr = adr(i); wr_data = v; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    do_reset();

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        rd(VEC[i][19:16], d);
        chk($sformatf("table row %0d", i), d, VEC[i][7:0]);
      end else begin
        wr(VEC[i][19:16], VEC[i][15:8]);
      end
    end

    // R13: reset after activity restores the quiet state
    wr(I_HI, 8'h3C);
    wr(I_ST, 8'h01);
    wr(I_FF, 8'hE1);
    rd(I_FF, d);
    chk("R5 irq after pop", {7'b0, irq}, 8'h01);
    wr(I_FF, 8'hE2);
    do_reset();
    chk("R13 irq low", {7'b0, irq}, 8'h00);
    rd(I_ST, d);   chk("R13 status cleared", d, 8'h00);
    rd(I_HI, d);   chk("R13 id restored", d, CHIP);
    rd(I_FF, d);   chk("R13 buffer empty", d, 8'h00);
    chk("R13 empty read keeps irq low", {7'b0, irq}, 8'h00);

    // R2: read data holds with no strobe
    wr(I_SQ, 8'h5B);
    rd(I_SQ, d);
    repeat (3) @(negedge clk);
    chk("R2 hold", rd_data, 8'h5B);

    // R1: low address bits ignored
    rd_raw(adr(I_SQ) | 8'h03, d); chk("R1 alias +3", d, 8'h5B);
    rd_raw(adr(I_SQ) | 8'h01, d); chk("R1 alias +1", d, 8'h5B);

    // R5 / R9: interrupt rises on pop, falls on cause read
    wr(I_ST, 8'h01);
    wr(I_FF, 8'hC7);
    rd(I_FF, d);
    chk("R3 single pop", d, 8'hC7);
    chk("R5 irq high", {7'b0, irq}, 8'h01);
    rd(I_ST, d);
    chk("R12 irq unchanged by plain read", {7'b0, irq}, 8'h01);
    rd(I_IN, d);
    chk("R9 irq low", {7'b0, irq}, 8'h00);

    // R7: pointers rewind after data-out empties the buffer
    wr(I_ST, 8'h00);
    wr(I_FF, 8'hA1);
    wr(I_FF, 8'hA2);
    rd(I_FF, d); chk("R4 zero out", d, 8'h00);
    rd(I_FF, d); chk("R4 zero out", d, 8'h00);
    wr(I_ST, 8'h01);
    wr(I_FF, 8'hB7);
    rd(I_FF, d); chk("R7 rewind", d, 8'hB7);

    // R8: 17 pushes, only 16 kept
    for (int i = 0; i < 17; i++) wr(I_FF, 8'h80 + 8'(i));
    for (int i = 0; i < 16; i++) begin
      rd(I_FF, d);
      chk("R8 full order", d, 8'h80 + 8'(i));
    end
    rd(I_FF, d); chk("R8 extra byte dropped", d, 8'h8F);

    // R14: write colliding with a read is dropped
    wr(I_CMD_IDX(), 8'h00);
    @(negedge clk);
    bus_addr = adr(I_ST); wr_data = 8'hEE; rd_stb = 1'b1; wr_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0;
    chk("R14 read returns old", rd_data, 8'h01);
    rd(I_ST, d); chk("R14 write dropped", d, 8'h01);
    @(negedge clk);
    bus_addr = adr(I_FF); wr_data = 8'hDD; rd_stb = 1'b1; wr_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0;
    rd(I_FF, d); chk("R14 no push on collision", d, 8'h8F);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic logic [3:0] I_CMD_IDX();
    return 4'd3;
  endfunction
endmodule